// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block turns a decoded load or store instruction into a 20-bit memory address and hands it to the memory controller through a request/acknowledge handshake. The instruction's 3-bit mode field picks the address source. Mode 0 is absolute: the address is the second 20-bit instruction half. Mode 1 is stack: the address comes from the stack pointer. Mode 2 is indexed: the address is the index register plus a signed displacement. Every other mode code is rejected.

In stack mode a store behaves as a push and a load as a pop. A push lowers the stack pointer by one before the access and uses the lowered value as the address. A pop uses the current stack pointer as the address and raises it by one afterwards. The updated stack pointer goes back to the register file with a one-cycle write strobe, and only once the memory has acknowledged the access. The stack pointer and index register values arrive as inputs and are captured when the instruction is accepted.

Top module: `ls_addr_unit`

## Requirements
- R1: After a synchronous reset, `mem_req`, `done`, `illegal_mode` and `sp_wr_en` are low and `op_ready` is high.
- R2: The mode is `op_head[12:10]`. Mode 0 puts the address `op_tail[19:0]` on `mem_addr`.
- R3: Mode 1 with `op_head[13]`=1 (store/push) addresses `sp_in - 1` mod 2^20. Mode 1 with `op_head[13]`=0 (load/pop) addresses `sp_in`.
- R4: Mode 2 addresses `ix_in` plus `op_head[9:0]`, taken as a two's-complement value from -512 to +511, with the sum reduced mod 2^20.
- R5: Mode codes 3 to 7 give a one-cycle `illegal_mode` pulse in the cycle after acceptance. They raise no `mem_req`, give no `sp_wr_en`, and leave `op_ready` high.
- R6: `mem_req` rises in the cycle after acceptance. It stays high, with `mem_addr` and `mem_write` unchanged, until the cycle after `mem_ack` is seen. `mem_write` equals `op_head[13]`.
- R7: `done` pulses for one cycle, in the cycle after `mem_req` and `mem_ack` are both high. `op_ready` is low from acceptance until that cycle.
- R8: `sp_wr_en` pulses together with `done`, and only for mode 1. `sp_wr_data` is then `sp_in - 1` for a push or `sp_in + 1` for a pop, mod 2^20.
- R9: `sp_in`, `ix_in`, `op_head` and `op_tail` are sampled only at acceptance. Changing them while a request is outstanding changes neither `mem_addr` nor `sp_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction offered; accepted when `op_ready` is high |
| op_ready | output | 1 | Unit idle and able to accept |
| op_head | input | 14 | First instruction half: [13] store, [12:10] mode, [9:0] displacement |
| op_tail | input | 20 | Second instruction half (absolute address) |
| sp_in | input | 20 | Current stack pointer |
| ix_in | input | 20 | Current index register |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 20 | Memory address |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_ack | input | 1 | Memory controller has completed the access |
| done | output | 1 | One-cycle completion pulse |
| illegal_mode | output | 1 | One-cycle pulse for a rejected mode code |
| sp_wr_en | output | 1 | Stack pointer write strobe |
| sp_wr_data | output | 20 | New stack pointer value |

## Verification
The hardest cases to reach are the wrap corners of the stack and index arithmetic. A push from stack pointer 0 must wrap to 0xFFFFF, a pop from 0xFFFFF must wrap to 0. An index of 0 with displacement -512 must wrap, and so must an index of 0xFFFFF with +511. The bench crosses all eight mode codes and both directions with stack pointer, index and displacement values placed on these corners, and with acknowledge delays of zero to three cycles. While each request is outstanding it overwrites every operand input, so the holding of the captured values is tested at the same time as the address.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    parameter int ADDR_W   = 20;
    parameter int HALF_W   = 20;
    parameter int DISP_W   = 10;
    parameter int MODE_LSB = 10;
    parameter int MODE_W   = 3;
    parameter int DIR_BIT  = 13;
    parameter int HEAD_W   = DIR_BIT + 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS   = 3'd0,
        AM_STACK = 3'd1,
        AM_INDEX = 3'd2,
        AM_BAD   = 3'd7
    } amode_e;

    typedef enum logic {
        LS_IDLE = 1'b0,
        LS_WAIT = 1'b1
    } ls_state_e;

    typedef struct packed {
        amode_e              kind;
        logic                is_store;
        addr_t               abs_addr;
        logic [DISP_W-1:0]   disp;
    } lsag_op_t;

    typedef struct packed {
        addr_t addr;
        addr_t next_sp;
        logic  sp_upd;
        logic  is_store;
    } lsag_req_t;

    function automatic addr_t sext_disp(input logic [DISP_W-1:0] d);
        return addr_t'({{(ADDR_W-DISP_W){d[DISP_W-1]}}, d});
    endfunction

endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
    import lsag_pkg::*;
(
    input  logic [HEAD_W-1:0] op_head,
    input  logic [HALF_W-1:0] op_tail,
    output lsag_op_t          op
);
    logic [MODE_W-1:0] mode_bits;

    assign mode_bits = op_head[MODE_LSB +: MODE_W];

    always_comb begin
        op.is_store = op_head[DIR_BIT];
        op.disp     = op_head[DISP_W-1:0];
        op.abs_addr = op_tail[ADDR_W-1:0];
        case (mode_bits)
            AM_ABS:   op.kind = AM_ABS;
            AM_STACK: op.kind = AM_STACK;
            AM_INDEX: op.kind = AM_INDEX;
            default:  op.kind = AM_BAD;
        endcase
    end
endmodule

// File: rtl/lsag_agen.sv
module lsag_agen
    import lsag_pkg::*;
(
    input  lsag_op_t  op,
    input  addr_t     sp_in,
    input  addr_t     ix_in,
    output lsag_req_t req
);
    addr_t sp_dec;
    addr_t sp_inc;
    addr_t ix_sum;

    assign sp_dec = sp_in - addr_t'(1);
    assign sp_inc = sp_in + addr_t'(1);
    assign ix_sum = ix_in + sext_disp(op.disp);

    always_comb begin
        req          = '0;
        req.is_store = op.is_store;
        case (op.kind)
            AM_ABS: begin
                req.addr = op.abs_addr;
            end
            AM_STACK: begin
                req.sp_upd = 1'b1;
                if (op.is_store) begin
                    req.addr    = sp_dec;
                    req.next_sp = sp_dec;
                end else begin
                    req.addr    = sp_in;
                    req.next_sp = sp_inc;
                end
            end
            AM_INDEX: begin
                req.addr = ix_sum;
            end
            default: begin
                req.addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsag_ctrl.sv
module lsag_ctrl
    import lsag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      op_valid,
    input  logic      bad_mode,
    input  lsag_req_t req_in,
    input  logic      mem_ack,
    output logic      op_ready,
    output logic      mem_req,
    output addr_t     mem_addr,
    output logic      mem_write,
    output logic      done,
    output logic      illegal_mode,
    output logic      sp_wr_en,
    output addr_t     sp_wr_data
);
    ls_state_e state;
    lsag_req_t hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= LS_IDLE;
            hold         <= '0;
            done         <= 1'b0;
            illegal_mode <= 1'b0;
            sp_wr_en     <= 1'b0;
            sp_wr_data   <= '0;
        end else begin
            done         <= 1'b0;
            illegal_mode <= 1'b0;
            sp_wr_en     <= 1'b0;
            case (state)
                LS_IDLE: begin
                    if (op_valid) begin
                        if (bad_mode) begin
                            illegal_mode <= 1'b1;
                        end else begin
                            hold  <= req_in;
                            state <= LS_WAIT;
                        end
                    end
                end
                LS_WAIT: begin
                    if (mem_ack) begin
                        done       <= 1'b1;
                        sp_wr_en   <= hold.sp_upd;
                        sp_wr_data <= hold.next_sp;
                        state      <= LS_IDLE;
                    end
                end
                default: state <= LS_IDLE;
            endcase
        end
    end

    assign op_ready  = (state == LS_IDLE);
    assign mem_req   = (state == LS_WAIT);
    assign mem_addr  = hold.addr;
    assign mem_write = hold.is_store;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write))); // R6
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req && mem_ack)); // R7
    AST_BUSY_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !op_ready); // R7
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_mode |-> (!mem_req && !sp_wr_en && !done)); // R5
    AST_SPWR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        sp_wr_en |-> done); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
endmodule

// File: rtl/ls_addr_unit.sv
module ls_addr_unit
    import lsag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [HEAD_W-1:0] op_head,
    input  logic [HALF_W-1:0] op_tail,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] ix_in,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    input  logic              mem_ack,
    output logic              done,
    output logic              illegal_mode,
    output logic              sp_wr_en,
    output logic [ADDR_W-1:0] sp_wr_data
);
    lsag_op_t  dec_op;
    lsag_req_t gen_req;
    logic      bad_mode;

    lsag_decode i_decode (
        .op_head (op_head),
        .op_tail (op_tail),
        .op      (dec_op)
    );

    lsag_agen i_agen (
        .op    (dec_op),
        .sp_in (sp_in),
        .ix_in (ix_in),
        .req   (gen_req)
    );

    assign bad_mode = (dec_op.kind == AM_BAD);

    lsag_ctrl i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .op_valid     (op_valid),
        .bad_mode     (bad_mode),
        .req_in       (gen_req),
        .mem_ack      (mem_ack),
        .op_ready     (op_ready),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_write    (mem_write),
        .done         (done),
        .illegal_mode (illegal_mode),
        .sp_wr_en     (sp_wr_en),
        .sp_wr_data   (sp_wr_data)
    );
endmodule

// File: tb/test_ls_addr_unit.sv
module test_ls_addr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [13:0] op_head = '0;
    logic [19:0] op_tail = '0;
    logic [19:0] sp_in = '0;
    logic [19:0] ix_in = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_write;
    logic        mem_ack = 1'b0;
    logic        done;
    logic        illegal_mode;
    logic        sp_wr_en;
    logic [19:0] sp_wr_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ls_addr_unit i_ls_addr_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_head(op_head), .op_tail(op_tail), .sp_in(sp_in), .ix_in(ix_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_write(mem_write),
        .mem_ack(mem_ack), .done(done), .illegal_mode(illegal_mode),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] mode, input logic dir, input logic [19:0] sp,
                          input logic [19:0] ix, input logic [9:0] disp,
                          input logic [19:0] absa, input int delay);
        logic [31:0] ea;
        logic [31:0] esp;
        int          dv;
        string       ta;
        bit          legal;
        bit          stk;
        legal = (mode <= 3'd2);
        stk   = (mode == 3'd1);
        dv    = disp[9] ? int'(disp) - 1024 : int'(disp);
        case (mode)
            3'd0:    begin ea = {12'd0, absa}; ta = "R2"; end
            3'd1:    begin ea = dir ? ((32'(sp) + 32'hFFFFF) & 32'hFFFFF) : 32'(sp); ta = "R3"; end
            default: begin ea = (32'(int'(sp) * 0 + int'(ix) + dv)) & 32'hFFFFF; ta = "R4"; end
        endcase
        esp = dir ? ((32'(sp) + 32'hFFFFF) & 32'hFFFFF) : ((32'(sp) + 1) & 32'hFFFFF);

        @(negedge clk);
        op_valid = 1'b1;
        op_head  = {dir, mode, disp};
        op_tail  = absa;
        sp_in    = sp;
        ix_in    = ix;
        @(negedge clk);
        op_valid = 1'b0;
        sp_in    = ~sp;
        ix_in    = ~ix;
        op_tail  = ~absa;
        op_head  = ~op_head;
        if (!legal) begin
            chk("R5 illegal pulse", 32'(illegal_mode), 1);
            chk("R5 no request", 32'(mem_req), 0);
            chk("R5 no sp write", 32'(sp_wr_en), 0);
            chk("R5 ready stays", 32'(op_ready), 1);
            @(negedge clk);
            chk("R5 pulse ends", 32'(illegal_mode), 0);
            chk("R5 still no request", 32'(mem_req), 0);
            return;
        end
        chk("R6 request raised", 32'(mem_req), 1);
        chk({ta, " address"}, 32'(mem_addr), ea);
        chk("R6 write flag", 32'(mem_write), 32'(dir));
        chk("R7 busy", 32'(op_ready), 0);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk("R6 request held", 32'(mem_req), 1);
            chk("R9 address held", 32'(mem_addr), ea);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R7 done pulse", 32'(done), 1);
        chk("R6 request dropped", 32'(mem_req), 0);
        chk("R8 sp strobe", 32'(sp_wr_en), 32'(stk));
        if (stk) chk("R8 R9 new sp", 32'(sp_wr_data), esp);
        chk("R7 ready again", 32'(op_ready), 1);
        @(negedge clk);
        chk("R7 done single", 32'(done), 0);
        chk("R8 strobe single", 32'(sp_wr_en), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] sp_v;
        logic [19:0] ix_v;
        logic [9:0]  d_v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 illegal", 32'(illegal_mode), 0);
        chk("R1 sp_wr_en", 32'(sp_wr_en), 0);
        chk("R1 ready", 32'(op_ready), 1);
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int k = 0; k < 4; k++) begin
                    case (k)
                        0:       begin sp_v = 20'h00000; ix_v = 20'h00000; d_v = 10'h200; end
                        1:       begin sp_v = 20'hFFFFF; ix_v = 20'hFFFFF; d_v = 10'h1FF; end
                        2:       begin sp_v = 20'h00001; ix_v = 20'h00010; d_v = 10'h3FF; end
                        default: begin sp_v = 20'h80000; ix_v = 20'h7FFF0; d_v = 10'h000; end
                    endcase
                    run_op(3'(m), 1'(d), sp_v, ix_v, d_v, 20'hABCDE ^ 20'(k * 20'h11111), k);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule